// File: doc/BRIEF.md
# DS3 Loss-of-Frame Detector

This block decides when a DS3 receive path has lost frame alignment. The framer marks each framing-bit position with a strobe: one strobe kind for the F bits inside each subframe, another for the M bits of the multiframe. With each strobe the framer also supplies the value the bit ought to carry. The detector compares the received bit against that expected value and shifts the error result into a history kept separately for each bit kind.

The F history spans the most recent 16 F bits and trips at 3 mismatches. The M history spans the most recent 4 M bits and trips at 2 mismatches. Either history alone raises the loss-of-frame level, which tells the framer to start a new alignment search. The level stays up, and both histories stay frozen, until the framer pulses its in-sync input. That pulse drops the level and empties both histories, so errors seen before the realignment cannot trip the alarm again.

Window lengths and thresholds are parameters, checked when the design is elaborated. The framer supplies the expected values. In normal use these are 1,0,0,1 for the four F bits of a subframe and 0,1,0 for the M bits of subframes 5 to 7.

Top module: `ds3_lof_detect`

## Requirements
- R1: When an F strobe makes the count of mismatched F bits among the last 16 F strobes reach 3, `lof` is 1 after the clock edge that samples that strobe.
- R2: The F history slides. An F mismatch older than the 16 most recent F strobes no longer counts toward the threshold.
- R3: When an M strobe makes the count of mismatched M bits among the last 4 M strobes reach 2, `lof` is 1 after the clock edge that samples that strobe.
- R4: The M history slides. An M mismatch older than the 4 most recent M strobes no longer counts.
- R5: Once set, `lof` stays 1, and strobes carrying mismatches have no effect on it, until `sync_ok` is sampled high. `lof` is 0 after the edge that samples `sync_ok`.
- R6: `sync_ok` empties both histories. Mismatches seen before it do not count toward either threshold afterwards.
- R7: A strobed bit counts as an error exactly when `rx_bit` differs from `expect_bit`. Matching bits never count, for an expected value of either 0 or 1.
- R8: After reset `lof` is 0 and both histories are empty.
- R9: When `sync_ok` is high in the same cycle as a strobe, `sync_ok` wins. `lof` is 0 after that edge, and the strobe is not recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Received bit at the strobed position |
| f_strobe | input | 1 | Current bit is an F framing bit |
| m_strobe | input | 1 | Current bit is an M framing bit |
| expect_bit | input | 1 | Value the strobed framing bit should carry |
| sync_ok | input | 1 | Pulse from the framer: alignment regained |
| lof | output | 1 | Loss-of-frame level |

## Verification
Every result is due one clock edge after its stimulus. A strobe or `sync_ok` sampled at a rising edge shows on `lof` straight after that edge, because the alarm flop is the only register between the inputs and the output. The bench changes inputs on the falling edge and reads `lof` at the following falling edge, one half period after the edge that produced the result. Tests that depend on the history window length first count out exactly the number of strobes after which a mismatch should leave the window. They then check that one further mismatch does not trip the alarm and that the one after it does.

// File: rtl/ds3_lof_pkg.sv
package ds3_lof_pkg;

   typedef enum logic [0:0] {
      LOF_CLEAR  = 1'b0,
      LOF_ACTIVE = 1'b1
   } lof_state_e;

endpackage

// File: rtl/lof_err_window.sv
module lof_err_window #(
   parameter int WIN = 16,
   parameter int TH  = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       upd,
   input  logic                       err,
   output logic [$clog2(WIN+1)-1:0]   cnt_o,
   output logic                       trip_o
);
   localparam int CW = $clog2(WIN + 1);

   generate
      if (WIN < 2) begin : g_bad_win
         $error("lof_err_window: WIN must be at least 2");
      end
      if (TH < 1 || TH > WIN) begin : g_bad_th
         $error("lof_err_window: TH must lie in 1..WIN");
      end
   endgenerate

   logic [WIN-1:0] hist_q;
   logic [WIN-1:0] hist_d;
   logic [CW-1:0]  pop [WIN+1];
   logic [CW-1:0]  pop_q [WIN+1];

   assign hist_d = {hist_q[WIN-2:0], err};

   // running sums over the shifted-in value and the held value
   assign pop[0]   = '0;
   assign pop_q[0] = '0;
   genvar gi;
   generate
      for (gi = 0; gi < WIN; gi++) begin : g_pop
         assign pop[gi+1]   = pop[gi]   + CW'(hist_d[gi]);
         assign pop_q[gi+1] = pop_q[gi] + CW'(hist_q[gi]);
      end
   endgenerate

   assign trip_o = upd && (pop[WIN] >= CW'(TH));
   assign cnt_o  = pop_q[WIN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else if (clr) begin
         hist_q <= '0;
      end else if (upd) begin
         hist_q <= hist_d;
      end
   end
endmodule

// File: rtl/lof_alarm.sv
module lof_alarm
   import ds3_lof_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic lof_o
);
   lof_state_e st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= LOF_CLEAR;
      end else if (clr) begin
         st_q <= LOF_CLEAR;
      end else if (set) begin
         st_q <= LOF_ACTIVE;
      end
   end

   assign lof_o = (st_q == LOF_ACTIVE);
endmodule

// File: rtl/ds3_lof_detect.sv
module ds3_lof_detect #(
   parameter int F_WIN = 16,
   parameter int F_TH  = 3,
   parameter int M_WIN = 4,
   parameter int M_TH  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_bit,
   input  logic f_strobe,
   input  logic m_strobe,
   input  logic expect_bit,
   input  logic sync_ok,
   output logic lof
);
   localparam int FCW = $clog2(F_WIN + 1);
   localparam int MCW = $clog2(M_WIN + 1);

   logic           mismatch;
   logic           f_upd, m_upd;
   logic           f_trip, m_trip;
   logic [FCW-1:0] f_cnt;
   logic [MCW-1:0] m_cnt;

   assign mismatch = rx_bit ^ expect_bit;
   // histories freeze while the alarm is up; sync pulse takes priority
   assign f_upd = f_strobe && !lof && !sync_ok;
   assign m_upd = m_strobe && !lof && !sync_ok;

   lof_err_window #(.WIN(F_WIN), .TH(F_TH)) u_fwin (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (sync_ok),
      .upd    (f_upd),
      .err    (mismatch),
      .cnt_o  (f_cnt),
      .trip_o (f_trip)
   );

   lof_err_window #(.WIN(M_WIN), .TH(M_TH)) u_mwin (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (sync_ok),
      .upd    (m_upd),
      .err    (mismatch),
      .cnt_o  (m_cnt),
      .trip_o (m_trip)
   );

   lof_alarm u_alarm (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (f_trip || m_trip),
      .clr   (sync_ok),
      .lof_o (lof)
   );
endmodule

// File: rtl/ds3_lof_detect_chk.sv
module ds3_lof_detect_chk #(
   parameter int F_WIN = 16,
   parameter int F_TH  = 3,
   parameter int M_WIN = 4,
   parameter int M_TH  = 2
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         f_strobe,
   input logic                         m_strobe,
   input logic                         sync_ok,
   input logic                         lof,
   input logic [$clog2(F_WIN+1)-1:0]   f_cnt,
   input logic [$clog2(M_WIN+1)-1:0]   m_cnt
);
   // R1: a settled F history below the trip level while no alarm
   a_r1_f_below_th: assert property (@(posedge clk) disable iff (!rst_n)
      !lof |-> (int'(f_cnt) < F_TH));

   // R3: same for the M history
   a_r3_m_below_th: assert property (@(posedge clk) disable iff (!rst_n)
      !lof |-> (int'(m_cnt) < M_TH));

   // R1 R3: the alarm only rises on a strobe without a sync pulse
   a_r1_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lof) |-> ($past(f_strobe || m_strobe) && !$past(sync_ok)));

   // R5: the alarm only drops on a sync pulse
   a_r5_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lof) |-> $past(sync_ok));

   // R5: held without sync
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (lof && !sync_ok) |=> lof);

   // R5: histories frozen while the alarm is up
   a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (lof && !sync_ok) |=> ($stable(f_cnt) && $stable(m_cnt)));

   // R6 R9: sync empties both histories and drops the alarm
   a_r6_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
      sync_ok |=> (!lof && f_cnt == '0 && m_cnt == '0));
endmodule

bind ds3_lof_detect ds3_lof_detect_chk #(
   .F_WIN(F_WIN), .F_TH(F_TH), .M_WIN(M_WIN), .M_TH(M_TH)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .f_strobe (f_strobe),
   .m_strobe (m_strobe),
   .sync_ok  (sync_ok),
   .lof      (lof),
   .f_cnt    (f_cnt),
   .m_cnt    (m_cnt)
);

// File: tb/ds3_lof_detect_tb.sv
module ds3_lof_detect_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_bit = 1'b0, f_strobe = 1'b0, m_strobe = 1'b0;
   logic expect_bit = 1'b0, sync_ok = 1'b0;
   logic lof;
   int   n_chk = 0;
   int   n_fail = 0;

   always #10 clk = ~clk;

   ds3_lof_detect u_dut (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .f_strobe(f_strobe),
      .m_strobe(m_strobe), .expect_bit(expect_bit), .sync_ok(sync_ok),
      .lof(lof)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: lof=%b expected %b", req, act, exp);
      end
   endtask

   // one strobe; kind 0 = F, 1 = M; result readable on return
   task automatic strobe(input bit kind, input logic exp, input logic bad);
      @(negedge clk);
      f_strobe   = (kind == 1'b0);
      m_strobe   = (kind == 1'b1);
      expect_bit = exp;
      rx_bit     = bad ? ~exp : exp;
      @(negedge clk);
      f_strobe = 1'b0;
      m_strobe = 1'b0;
   endtask

   task automatic resync();
      @(negedge clk);
      sync_ok = 1'b1;
      @(negedge clk);
      sync_ok = 1'b0;
   endtask

   task automatic t_reset_and_f_trip();
      chk("R8 reset", lof, 1'b0);
      strobe(0, 1'b1, 1); strobe(0, 1'b0, 1);
      chk("R8 empty after reset", lof, 1'b0);
      strobe(0, 1'b1, 1);
      chk("R1 third F error", lof, 1'b1);
   endtask

   task automatic t_hold_and_clear();
      strobe(0, 1'b0, 1); strobe(1, 1'b1, 1); strobe(1, 1'b0, 0);
      chk("R5 held under strobes", lof, 1'b1);
      resync();
      chk("R5 cleared by sync", lof, 1'b0);
   endtask

   task automatic t_f_slide();
      strobe(0, 1'b1, 1); strobe(0, 1'b1, 1);
      for (int i = 0; i < 14; i++) strobe(0, 1'b0, 0);
      strobe(0, 1'b1, 1);
      chk("R2 oldest F error aged out", lof, 1'b0);
      strobe(0, 1'b1, 1);
      chk("R2 second F error aged out", lof, 1'b0);
      strobe(0, 1'b1, 1);
      chk("R2 three in window", lof, 1'b1);
      resync();
   endtask

   task automatic t_m_trip_slide();
      strobe(1, 1'b0, 1);
      chk("R3 one M error", lof, 1'b0);
      strobe(1, 1'b1, 1);
      chk("R3 second M error", lof, 1'b1);
      resync();
      strobe(1, 1'b0, 1);
      for (int i = 0; i < 3; i++) strobe(1, 1'b1, 0);
      strobe(1, 1'b0, 1);
      chk("R4 old M error aged out", lof, 1'b0);
      strobe(1, 1'b1, 1);
      chk("R4 two in M window", lof, 1'b1);
      resync();
   endtask

   task automatic t_compare();
      // subframe F pattern 1,0,0,1 and M pattern 0,1,0, all matching
      for (int i = 0; i < 20; i++) strobe(0, (i % 4 == 0) || (i % 4 == 3), 0);
      for (int i = 0; i < 9; i++) strobe(1, (i % 3 == 1), 0);
      chk("R7 matching bits never count", lof, 1'b0);
      strobe(0, 1'b0, 1); strobe(0, 1'b0, 1); strobe(0, 1'b0, 1);
      chk("R7 mismatch with expected 0", lof, 1'b1);
      resync();
   endtask

   task automatic t_sync_history();
      strobe(0, 1'b1, 1); strobe(0, 1'b1, 1);
      resync();
      strobe(0, 1'b1, 1);
      chk("R6 F history emptied", lof, 1'b0);
      strobe(1, 1'b0, 1);
      resync();
      strobe(1, 1'b0, 1);
      chk("R6 M history emptied", lof, 1'b0);
      resync();
   endtask

   task automatic t_priority();
      strobe(0, 1'b1, 1); strobe(0, 1'b1, 1);
      @(negedge clk);
      f_strobe = 1'b1; expect_bit = 1'b1; rx_bit = 1'b0; sync_ok = 1'b1;
      @(negedge clk);
      f_strobe = 1'b0; sync_ok = 1'b0;
      chk("R9 sync wins over tripping strobe", lof, 1'b0);
      strobe(0, 1'b1, 1);
      chk("R9 colliding strobe not recorded", lof, 1'b0);
      resync();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_and_f_trip();
      t_hold_and_clear();
      t_f_slide();
      t_m_trip_slide();
      t_compare();
      t_sync_history();
      t_priority();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #4000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule